// File: doc/BRIEF.md
# Serial Line Mode Control Register and Data Router

This block holds one eight-bit control register that software can write and read back. Its bits set two active-low handshake outputs to the modem, gate the interrupt line, and select how serial data moves between the external pins and an attached transmitter and receiver. The serializer, the deserializer and the bit-rate clock are outside this block. The block only chooses the source that drives the outgoing line and the receiver's input, and it tells the transmitter whether it may send.

Four line modes are available. In plain operation the transmitter drives the line and the receiver listens to the pin. In break mode the line is forced low for every bit of every character. In echo mode the incoming pin is copied straight to the outgoing pin through gates only, with no flop in the path, and the transmitter is held off. In loop test mode the transmitter's stream goes straight into the receiver, the outgoing pin idles high and the incoming pin is ignored.

Top module: `uart_mode_router`

## Requirements
- R1: A write (`reg_wr` high at a rising edge) loads all eight bits of `reg_wdata`, and `reg_rdata` shows them after that edge. Without a write, the register keeps its value.
- R2: While `rst_n` is low, the register clears to 0x00. This gives `reg_rdata`=0, `dtr_n`=1, `rts_n`=1, `intr`=0 and plain mode.
- R3: `dtr_n` is the inverse of register bit 0 and `rts_n` is the inverse of register bit 1. A bit value of 1 drives its pin low.
- R4: When bit 2 is 0, `intr` is 0 whatever `irq_req` does. When bit 2 is 1, `intr` equals `irq_req`.
- R5: Bits 4:3 select the mode: 00 plain, 01 break, 10 echo, 11 loop test. In plain mode `sdo`=`tx_ser`, `rx_ser`=`sdi` and `tx_en`=1.
- R6: In break mode `sdo` is 0 for any `tx_ser`, while `tx_en`=1 and `rx_ser`=`sdi`.
- R7: In echo mode `sdo` equals `sdi` in the same cycle with no clock delay, `rx_ser`=`sdi`, and `tx_en`=0.
- R8: In echo mode a change on `tx_ser` has no effect on `sdo`.
- R9: In loop test mode `rx_ser`=`tx_ser` and `sdo`=1, whatever the value of `sdi`, and `tx_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_req | input | 1 | Combined interrupt request from the serial core |
| intr | output | 1 | Gated interrupt output |
| tx_ser | input | 1 | Serial stream from the transmitter |
| tx_en | output | 1 | Permission for the transmitter to send |
| rx_ser | output | 1 | Serial stream into the receiver |
| sdi | input | 1 | Incoming serial pin |
| sdo | output | 1 | Outgoing serial pin |

## Verification
The assertions assume that `irq_req`, `tx_ser` and `sdi` are settled at each rising clock edge, because the routing and gating paths are combinational and are sampled there. They also assume that `reg_wr` is low during reset. The bench changes every input only on falling edges or between edges, and keeps `reg_wr` low until reset has been released. It compares outputs one nanosecond after each change, so the combinational paths have settled and the reading is taken away from the edge.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_BREAK = 2'b01,
        MODE_ECHO  = 2'b10,
        MODE_LOOP  = 2'b11
    } line_mode_e;

    localparam int CTRL_W      = 8;
    localparam int DTR_POS     = 0;
    localparam int RTS_POS     = 1;
    localparam int IEN_POS     = 2;
    localparam int MODE_LSB    = 3;
    localparam int MODE_W      = 2;
endpackage

// File: rtl/mode_ctrl_reg.sv
module mode_ctrl_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value
);
    typedef struct packed {
        logic [REG_W-1:0] bits;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.bits = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.bits;

    // R1: a write lands on the following edge
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (value == $past(wdata)));
    // R1: with no write the register holds its value
    a_r1_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(value));
endmodule

// File: rtl/modem_pin_drive.sv
module modem_pin_drive (
    input  logic dtr_bit,
    input  logic rts_bit,
    input  logic ien_bit,
    input  logic irq_req,
    output logic dtr_n,
    output logic rts_n,
    output logic intr
);
    always_comb begin
        dtr_n = ~dtr_bit;
        rts_n = ~rts_bit;
        intr  = ien_bit & irq_req;
    end
endmodule

// File: rtl/serial_path_mux.sv
module serial_path_mux
    import uart_mode_pkg::*;
(
    input  line_mode_e mode,
    input  logic       tx_ser,
    input  logic       sdi,
    output logic       sdo,
    output logic       rx_ser,
    output logic       tx_en
);
    always_comb begin
        sdo    = tx_ser;
        rx_ser = sdi;
        tx_en  = 1'b1;
        unique case (mode)
            MODE_PLAIN: begin
                sdo = tx_ser;
            end
            MODE_BREAK: begin
                sdo = 1'b0;
            end
            MODE_ECHO: begin
                sdo   = sdi;
                tx_en = 1'b0;
            end
            MODE_LOOP: begin
                sdo    = 1'b1;
                rx_ser = tx_ser;
            end
            default: begin
                sdo = tx_ser;
            end
        endcase
    end
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
    import uart_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              dtr_n,
    output logic              rts_n,
    input  logic              irq_req,
    output logic              intr,
    input  logic              tx_ser,
    output logic              tx_en,
    output logic              rx_ser,
    input  logic              sdi,
    output logic              sdo
);
    logic [CTRL_W-1:0] ctrl_q;
    line_mode_e        mode;

    mode_ctrl_reg #(.REG_W(CTRL_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .value (ctrl_q)
    );

    assign reg_rdata = ctrl_q;
    assign mode      = line_mode_e'(ctrl_q[MODE_LSB +: MODE_W]);

    modem_pin_drive u_pins (
        .dtr_bit (ctrl_q[DTR_POS]),
        .rts_bit (ctrl_q[RTS_POS]),
        .ien_bit (ctrl_q[IEN_POS]),
        .irq_req (irq_req),
        .dtr_n   (dtr_n),
        .rts_n   (rts_n),
        .intr    (intr)
    );

    serial_path_mux u_mux (
        .mode   (mode),
        .tx_ser (tx_ser),
        .sdi    (sdi),
        .sdo    (sdo),
        .rx_ser (rx_ser),
        .tx_en  (tx_en)
    );

    // R3: a written handshake bit reaches its pin inverted
    a_r3_dtr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (dtr_n == !$past(reg_wdata[DTR_POS])));
    a_r3_rts_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (rts_n == !$past(reg_wdata[RTS_POS])));
    // R4: interrupt held low while the enable bit read back is 0
    a_r4_intr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[IEN_POS] |-> !intr);
    // R6: break mode keeps the line low
    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[MODE_LSB +: MODE_W] == 2'b01) |-> !sdo);
    // R7: echo mode holds the transmitter off and mirrors the pin
    a_r7_echo_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[MODE_LSB +: MODE_W] == 2'b10) |-> (!tx_en && sdo == sdi));
    // R9: loop test feeds the receiver from the transmitter, line idles
    a_r9_loop_path: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[MODE_LSB +: MODE_W] == 2'b11) |-> (sdo && rx_ser == tx_ser));
endmodule

// File: tb/uart_mode_router_tb.sv
module uart_mode_router_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dtr_n, rts_n, intr, tx_en, rx_ser, sdo;
    logic       irq_req = 1'b0;
    logic       tx_ser = 1'b1;
    logic       sdi = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] model = 8'h00;
    string      tag_q[$];
    logic [13:0] exp_q[$];
    event        sample_ev;

    always #10 clk = ~clk;

    uart_mode_router u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dtr_n(dtr_n), .rts_n(rts_n),
        .irq_req(irq_req), .intr(intr), .tx_ser(tx_ser), .tx_en(tx_en),
        .rx_ser(rx_ser), .sdi(sdi), .sdo(sdo)
    );

    // Expected outputs {rdata, rts_n, dtr_n, intr, sdo, rx_ser, tx_en}
    function automatic logic [13:0] predict(logic [7:0] r, logic irq, logic tx, logic si);
        logic e_sdo, e_rx, e_en;
        case (r[4:3])
            2'b00:   begin e_sdo = tx;   e_rx = si; e_en = 1'b1; end
            2'b01:   begin e_sdo = 1'b0; e_rx = si; e_en = 1'b1; end
            2'b10:   begin e_sdo = si;   e_rx = si; e_en = 1'b0; end
            default: begin e_sdo = 1'b1; e_rx = tx; e_en = 1'b1; end
        endcase
        return {r, ~r[1], ~r[0], r[2] & irq, e_sdo, e_rx, e_en};
    endfunction

    task automatic push_expect(string tag);
        tag_q.push_back(tag);
        exp_q.push_back(predict(model, irq_req, tx_ser, sdi));
        -> sample_ev;
        #2;
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        model = v;
        #1;
        reg_wr = 1'b0;
        reg_wdata = ~v;
    endtask

    task automatic drive(logic irq, logic tx, logic si, string tag);
        irq_req = irq;
        tx_ser = tx;
        sdi = si;
        #1;
        push_expect(tag);
    endtask

    // Monitor: pops expected items and compares with live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                string t;
                logic [13:0] e, a;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                a = {reg_rdata, rts_n, dtr_n, intr, sdo, rx_ser, tx_en};
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #25;
        drive(1'b1, 1'b1, 1'b1, "R2 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        drive(1'b1, 1'b0, 1'b1, "R2 after reset release");

        // R1 and R3: readback and handshake pins
        write_reg(8'hE1);
        drive(1'b0, 1'b1, 1'b1, "R1 R3 dtr only");
        write_reg(8'h02);
        drive(1'b0, 1'b1, 1'b1, "R1 R3 rts only");
        repeat (3) @(posedge clk);
        #3;
        drive(1'b0, 1'b1, 1'b1, "R1 hold without write");
        write_reg(8'hA3);
        drive(1'b0, 1'b1, 1'b1, "R1 R3 both asserted upper bits");

        // R4: interrupt gate
        write_reg(8'h00);
        drive(1'b1, 1'b1, 1'b1, "R4 gate closed irq high");
        write_reg(8'h04);
        drive(1'b1, 1'b1, 1'b1, "R4 gate open irq high");
        drive(1'b0, 1'b1, 1'b1, "R4 gate open irq low");

        // R5..R9: every mode with every tx/sdi pair
        for (int m = 0; m < 4; m++) begin
            write_reg({3'b010, m[1:0], 3'b101});
            for (int p = 0; p < 4; p++) begin
                case (m)
                    0: drive(1'b1, p[0], p[1], "R5 plain routing");
                    1: drive(1'b1, p[0], p[1], "R6 break forces low");
                    2: drive(1'b1, p[0], p[1], "R7 echo routing");
                    default: drive(1'b1, p[0], p[1], "R9 loop routing");
                endcase
            end
        end

        // R8: echo ignores tx_ser toggles
        write_reg(8'h10);
        drive(1'b0, 1'b0, 1'b1, "R8 echo tx low");
        drive(1'b0, 1'b1, 1'b1, "R8 echo tx high");
        drive(1'b0, 1'b0, 1'b0, "R8 echo sdi low tx low");
        drive(1'b0, 1'b1, 1'b0, "R8 echo sdi low tx high");

        // R9: loop ignores sdi across a clock edge
        write_reg(8'h18);
        drive(1'b0, 1'b0, 1'b1, "R9 loop sdi high");
        @(posedge clk);
        #3;
        drive(1'b0, 1'b0, 1'b0, "R9 loop sdi low");

        #5;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule